// File: doc/BRIEF.md
# Prioritized Interrupt Collector

The block gathers a set of level-sensitive interrupt sources and drives a single request line towards a processor. Every source has a small configuration register that holds an enable bit and a priority. Among the enabled sources that are pending, the source with the highest priority wins. When several winners share that priority, the source with the lowest number wins.

The processor finds out which source won by reading a status register. That read returns the source's vector number and puts the source's priority level in service. While a level is in service, only a source of strictly higher priority can raise the request line again, so handlers nest by priority. Software can also lower the request line for the current source by writing to a vector register; the data written there is not used. Service of a level ends when software writes a one-hot level mask to an acknowledge register. A status read that finds nothing eligible returns a reserved spurious vector.

Software reaches all registers through a simple register bus with a byte address, a write strobe and a read strobe. Read data is registered.

Top module: `prio_irq_collector`

## Requirements
- R1: Source n has a configuration register at byte address 0x10*n (n = 0..63). Bits [1:0] hold the priority (3 is the highest) and bit 2 holds the enable. A write at offset +0x0 replaces the register, and a read at any of offsets +0x0, +0x4 or +0x8 returns it.
- R2: A write at offset +0x4 sets every register bit that is written as 1. A write at offset +0x8 clears every register bit that is written as 1. Bits written as 0 keep their value.
- R3: A source whose enable bit is 0 never wins arbitration and never raises irq_o, even while its input is high.
- R4: Reading the status register at 0x400 returns the winner's number in bits [6:0]. The winner has the highest priority among the enabled, pending, eligible sources; a tie goes to the lowest source number.
- R5: A status read that returns a valid vector puts the winner's priority level in service. While any level is in service, only sources with a priority strictly above the highest level in service are eligible.
- R6: When no source is eligible, a status read returns 0x7F and puts no level in service.
- R7: Any write to the vector register at 0x410, whatever its data, lowers irq_o for the current winner's level and every level below it. A source of higher priority still raises irq_o. The hold ends at the next write to the level-acknowledge register.
- R8: A write to the level-acknowledge register at 0x420 takes each level L whose bit L is 1 in bits [3:0] out of service.
- R9: After reset every enable and priority is 0, no level is in service, irq_o is low and a status read returns 0x7F.
- R10: irq_o changes on the first clock edge after the inputs or the state that decide it. rdata_o holds the read value one clock edge after rd_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt inputs, one per source |
| addr_i | input | 12 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
irq_o is a register, so it is due on the first edge after a change at src_i or after a bus write. The bench checks that it still reads low before that edge and high after it. Read data appears one edge after the read strobe, so each read task drives the strobe on a falling edge and samples rdata_o on the next falling edge. Level checks on irq_o that follow a claim, an acknowledge or a vector write wait two full cycles, so the state update and the registered output have both taken effect before the bench samples.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // register sub-slot inside each 0x10 source window, decoded from addr[3:2]
  typedef enum logic [1:0] {
    SUB_RW  = 2'd0,
    SUB_SET = 2'd1,
    SUB_CLR = 2'd2,
    SUB_NONE = 2'd3
  } sub_slot_e;

  localparam int unsigned SRC_STRIDE = 16;
endpackage

// File: rtl/src_cfg_bank.sv
module src_cfg_bank
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 2,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  sub_slot_e                       sub_i,
  input  logic [PRIO_W:0]                 wdata_i,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o
);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic [PRIO_W:0] cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q <= '0;
      end else if (we_i && idx_i == IDX_W'(n)) begin
        case (sub_i)
          SUB_RW:  cfg_q <= wdata_i;
          SUB_SET: cfg_q <= cfg_q | wdata_i;
          SUB_CLR: cfg_q <= cfg_q & ~wdata_i;
          default: cfg_q <= cfg_q;
        endcase
      end
    end
    assign en_o[n]   = cfg_q[PRIO_W];
    assign prio_o[n] = cfg_q[PRIO_W-1:0];
  end

endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 2,
  localparam int unsigned IDX_W   = $clog2(NUM_SRC),
  localparam int unsigned NUM_LVL = 1 << PRIO_W
) (
  input  logic [NUM_SRC-1:0]              pend_i,
  input  logic [NUM_SRC-1:0]              en_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [NUM_LVL-1:0]              isr_i,
  output logic                            valid_o,
  output logic [IDX_W-1:0]                idx_o,
  output logic [PRIO_W-1:0]               prio_o
);

  logic              any_isr;
  logic [PRIO_W-1:0] top_lvl;
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    any_isr = |isr_i;
    top_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (isr_i[l]) top_lvl = PRIO_W'(l);
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_SRC; n++) begin
      elig[n] = pend_i[n] && en_i[n] && (!any_isr || prio_i[n] > top_lvl);
    end
  end

  // scan downward with >= so the lowest index wins ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int n = NUM_SRC - 1; n >= 0; n--) begin
      if (elig[n] && (!valid_o || prio_i[n] >= prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(n);
        prio_o  = prio_i[n];
      end
    end
  end

endmodule

// File: rtl/level_tracker.sv
module level_tracker #(
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned NUM_LVL = 1 << PRIO_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               claim_i,
  input  logic [PRIO_W-1:0]  claim_lvl_i,
  input  logic               ack_i,
  input  logic [NUM_LVL-1:0] ack_mask_i,
  input  logic               vec_we_i,
  input  logic               win_valid_i,
  input  logic [PRIO_W-1:0]  win_prio_i,
  output logic [NUM_LVL-1:0] isr_o,
  output logic               irq_o
);

  logic [NUM_LVL-1:0] isr_q, isr_set, isr_clr;
  logic               mute_q, suppress, irq_q;
  logic [PRIO_W-1:0]  mute_lvl_q;

  assign isr_set  = claim_i ? (NUM_LVL'(1) << claim_lvl_i) : '0;
  assign isr_clr  = ack_i ? ack_mask_i : '0;
  assign suppress = mute_q && (win_prio_i <= mute_lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q      <= '0;
      mute_q     <= 1'b0;
      mute_lvl_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      isr_q <= (isr_q | isr_set) & ~isr_clr;
      if (vec_we_i && win_valid_i) begin
        mute_q     <= 1'b1;
        mute_lvl_q <= win_prio_i;
      end else if (ack_i) begin
        mute_q <= 1'b0;
      end
      irq_q <= win_valid_i && !suppress;
    end
  end

  assign isr_o = isr_q;
  assign irq_o = irq_q;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_chk
    assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && ack_mask_i[l]) |=> !isr_q[l]);
    assert_claim_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_i && claim_lvl_i == PRIO_W'(l) && !(ack_i && ack_mask_i[l])) |=> isr_q[l]);
  end

  assert_mute_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_q && win_valid_i && win_prio_i <= mute_lvl_q) |=> !irq_q);

endmodule

// File: rtl/prio_irq_collector.sv
module prio_irq_collector
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 2,
  parameter int unsigned VEC_W   = 7,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);

  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned NUM_LVL  = 1 << PRIO_W;
  localparam int unsigned SRC_SPAN = NUM_SRC * SRC_STRIDE;
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(SRC_SPAN);
  localparam logic [ADDR_W-1:0] VECTOR_A = ADDR_W'(SRC_SPAN + SRC_STRIDE);
  localparam logic [ADDR_W-1:0] LVACK_A  = ADDR_W'(SRC_SPAN + 2 * SRC_STRIDE);
  localparam logic [VEC_W-1:0]  SPURIOUS = '1;

  logic                           in_src;
  logic [IDX_W-1:0]               src_idx;
  sub_slot_e                      sub;
  logic [NUM_SRC-1:0]             en;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_LVL-1:0]             isr;
  logic                           win_valid;
  logic [IDX_W-1:0]               win_idx;
  logic [PRIO_W-1:0]              win_prio;
  logic                           status_rd, vec_we, ack_we, cfg_we;
  logic [DATA_W-1:0]              rd_mux, rdata_q;

  assign in_src    = addr_i < STATUS_A;
  assign src_idx   = addr_i[IDX_W+3:4];
  assign sub       = sub_slot_e'(addr_i[3:2]);
  assign cfg_we    = wr_en_i && in_src && sub != SUB_NONE;
  assign status_rd = rd_en_i && addr_i == STATUS_A;
  assign vec_we    = wr_en_i && addr_i == VECTOR_A;
  assign ack_we    = wr_en_i && addr_i == LVACK_A;

  src_cfg_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we),
    .idx_i   (src_idx),
    .sub_i   (sub),
    .wdata_i (wdata_i[PRIO_W:0]),
    .en_o    (en),
    .prio_o  (prio)
  );

  prio_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .pend_i  (src_i),
    .en_i    (en),
    .prio_i  (prio),
    .isr_i   (isr),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  level_tracker #(.PRIO_W(PRIO_W)) u_lvl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .claim_i     (status_rd && win_valid),
    .claim_lvl_i (win_prio),
    .ack_i       (ack_we),
    .ack_mask_i  (wdata_i[NUM_LVL-1:0]),
    .vec_we_i    (vec_we),
    .win_valid_i (win_valid),
    .win_prio_i  (win_prio),
    .isr_o       (isr),
    .irq_o       (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (in_src) begin
      rd_mux[PRIO_W:0] = {en[src_idx], prio[src_idx]};
    end else if (addr_i == STATUS_A) begin
      rd_mux[VEC_W-1:0] = win_valid ? VEC_W'(win_idx) : SPURIOUS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  assert_win_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid |-> (src_i[win_idx] && en[win_idx]));
  assert_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd && !win_valid) |=> rdata_o[VEC_W-1:0] == SPURIOUS);
  assert_no_claim_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd && !win_valid && !ack_we) |=> $stable(isr));

endmodule

// File: tb/prio_irq_collector_test.sv
module prio_irq_collector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [11:0] STATUS_A = 12'h400;
  localparam logic [11:0] VECTOR_A = 12'h410;
  localparam logic [11:0] LVACK_A  = 12'h420;

  // {sources, expected vector, level to acknowledge}
  localparam int NV = 6;
  localparam logic [72:0] TBL [NV] = '{
    {64'h0000_0000_0000_0220, 7'd5,    2'd2},
    {64'h0000_0002_0000_0001, 7'd33,   2'd1},
    {64'h0000_0000_0010_0000, 7'h7F,   2'd0},
    {64'h8000_0000_0000_0021, 7'd63,   2'd3},
    {64'h0000_0000_0000_0000, 7'h7F,   2'd0},
    {64'h0000_0000_0000_0201, 7'd9,    2'd2}
  };

  prio_irq_collector uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got 0x1 expected 0x0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R9 reset state
    check(irq == 1'b0, "R9 irq after reset", 32'(irq), 0);
    rd(12'h3F0, d); check(d == 0, "R9 cfg after reset", d, 0);
    rd(STATUS_A, d); check(d == 32'h7F, "R9 R6 status after reset", d, 32'h7F);

    // R1 layout and spacing
    wr(12'h110, 32'h6);
    rd(12'h110, d); check(d == 32'h6, "R1 cfg readback", d, 32'h6);
    rd(12'h118, d); check(d == 32'h6, "R1 alias read", d, 32'h6);
    rd(12'h120, d); check(d == 32'h0, "R1 neighbour untouched", d, 32'h0);
    // R2 set and clear aliases
    wr(12'h114, 32'h1);
    rd(12'h110, d); check(d == 32'h7, "R2 set alias", d, 32'h7);
    wr(12'h118, 32'h4);
    rd(12'h110, d); check(d == 32'h3, "R2 clr alias", d, 32'h3);
    wr(12'h110, 32'h0);

    // configure: src0 p0, src5 p2, src9 p2, src20 p3 disabled, src33 p1, src63 p3
    wr(12'h000, 32'h4); wr(12'h050, 32'h6); wr(12'h090, 32'h6);
    wr(12'h140, 32'h3); wr(12'h210, 32'h5); wr(12'h3F0, 32'h7);

    // R4 R3 R6 arbitration table
    for (int i = 0; i < NV; i++) begin
      logic [63:0] s;
      logic [6:0]  ev;
      logic [1:0]  lv;
      {s, ev, lv} = TBL[i];
      @(negedge clk); src = s;
      settle();
      check(irq == (ev != 7'h7F), "R3 R4 irq for vector", 32'(irq), 32'(ev != 7'h7F));
      rd(STATUS_A, d);
      check(d == 32'(ev), "R4 R6 status vector", d, 32'(ev));
      if (ev != 7'h7F) wr(LVACK_A, 32'(1) << lv);
      @(negedge clk); src = '0;
      settle();
    end

    // R10 irq timing: one edge after the input change
    @(negedge clk); src = 64'h1;
    #1; check(irq == 1'b0, "R10 irq before edge", 32'(irq), 0);
    @(negedge clk); check(irq == 1'b1, "R10 irq after one edge", 32'(irq), 1);
    @(negedge clk); src = '0;
    settle();

    // R5 nesting
    @(negedge clk); src = 64'h2_0000_0000;
    settle();
    rd(STATUS_A, d); check(d == 33, "R5 claim vector", d, 33);
    settle(); check(irq == 1'b0, "R5 irq low after claim", 32'(irq), 0);
    @(negedge clk); src = src | 64'h1;
    settle(); check(irq == 1'b0, "R5 lower level blocked", 32'(irq), 0);
    @(negedge clk); src = src | 64'h20;
    settle(); check(irq == 1'b1, "R5 higher level nests", 32'(irq), 1);
    rd(STATUS_A, d); check(d == 5, "R5 nested vector", d, 5);
    settle(); check(irq == 1'b0, "R5 same level blocked", 32'(irq), 0);
    @(negedge clk); src = 64'h2_0000_0001;
    wr(LVACK_A, 32'h4);
    settle(); check(irq == 1'b0, "R8 outer level still in service", 32'(irq), 0);
    wr(LVACK_A, 32'h2);
    settle(); check(irq == 1'b1, "R8 ack releases level", 32'(irq), 1);
    rd(STATUS_A, d); check(d == 33, "R8 reclaim vector", d, 33);
    wr(LVACK_A, 32'h2);
    @(negedge clk); src = '0;
    settle();

    // R7 vector write hold
    @(negedge clk); src = 64'h2_0000_0000;
    settle(); check(irq == 1'b1, "R7 irq before vector write", 32'(irq), 1);
    wr(VECTOR_A, 32'hDEAD_BEEF);
    settle(); check(irq == 1'b0, "R7 vector write lowers irq", 32'(irq), 0);
    @(negedge clk); src = src | 64'h8000_0000_0000_0000;
    settle(); check(irq == 1'b1, "R7 higher level still raises", 32'(irq), 1);
    @(negedge clk); src = 64'h2_0000_0000;
    settle(); check(irq == 1'b0, "R7 hold persists", 32'(irq), 0);
    rd(STATUS_A, d); check(d == 33, "R7 status still reports winner", d, 33);
    wr(LVACK_A, 32'h2);
    settle(); check(irq == 1'b1, "R7 ack ends hold", 32'(irq), 1);

    // R3 disable at runtime
    wr(12'h218, 32'h4);
    settle(); check(irq == 1'b0, "R3 disabled source quiet", 32'(irq), 0);
    rd(STATUS_A, d); check(d == 32'h7F, "R3 R6 disabled gives spurious", d, 32'h7F);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule